// File: doc/BRIEF.md
# Translation context and quadrant decoder

This block sits at the front of a two-stage address translation path. Each request carries a 64-bit effective address, the hypervisor-state bit, a relocation-enable flag and an instruction-fetch flag, together with the current partition register, process ID register and real-mode offset register. The block uses the top two address bits (the quadrant) to choose the partition ID and process ID for the later table walks. The choice differs between hypervisor and guest state. The block also reports which translation stages the request needs.

A hypervisor access with relocation off needs no table walk. For such an access the block builds the real address directly and grants full access. An address that is malformed, or that falls in a quadrant the current state may not use, produces a segment fault instead of a context. The fault is tagged with the access type, so that downstream logic can pick the instruction-side or the data-side interrupt. Results leave through one register stage with a valid/ready handshake.

Top module: `xlate_ctx_dec`

## Requirements
- R1: When the access is translated (any case except hypervisor state with relocation off), a nonzero value in any effective-address bit 61 down to 52 (LSB = bit 0) raises `seg_fault`.
- R2: In hypervisor state with relocation on, the quadrant is `ea[63:62]`. Quadrant 0 gives partition 0 and the process register. Quadrant 1 gives the partition register and the process register. Quadrant 2 gives the partition register and process 0. Quadrant 3 gives 0 for both.
- R3: In guest state, quadrant 0 gives the partition register and the process register. Quadrant 3 gives the partition register and process 0. Quadrants 1 and 2 raise `seg_fault`.
- R4: A faulting result has `lpid`, `pid`, `raddr`, `need_proc`, `need_part` and `full_perm` all zero. `fault_ifetch` equals the request's `ifetch` when `seg_fault` is 1, and is 0 otherwise.
- R5: In hypervisor state with relocation off, `raddr` is `ea` with bits 63:60 cleared. The real-mode offset is ORed in only when `ea[63]` is 0. `full_perm` is 1, both stage flags are 0, and bits 61:52 are ignored, so they never cause a fault.
- R6: Stage flags: guest state with relocation off gives `need_part`=1 and `need_proc`=0. Guest state with relocation on gives both flags set. Hypervisor state with relocation on gives `need_proc`=1, and `need_part`=1 only when the selected partition ID is nonzero.
- R7: A translated access that does not fault outputs `raddr` = `ea` with bits 63:62 cleared, and `full_perm` = 0.
- R8: `in_ready` is high whenever the output register is empty or `out_ready` is high. A request accepted on a clock edge is presented with `out_valid` high after that same edge.
- R9: While `out_valid` is high and `out_ready` is low, every output holds its value and no new request is accepted.
- R10: After a synchronous reset (`rst_n` low), `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| ea | input | 64 | Effective address |
| hv | input | 1 | Hypervisor state |
| reloc | input | 1 | Relocation enabled |
| ifetch | input | 1 | Access is an instruction fetch |
| lpid_reg | input | 12 | Current partition register |
| pid_reg | input | 20 | Process ID register |
| rmor | input | 64 | Real-mode offset register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| seg_fault | output | 1 | Segment fault |
| fault_ifetch | output | 1 | Fault was on an instruction fetch |
| lpid | output | 12 | Selected partition ID |
| pid | output | 20 | Selected process ID |
| raddr | output | 64 | Real address, or address handed to the walk |
| need_proc | output | 1 | Process-scoped stage required |
| need_part | output | 1 | Partition-scoped stage required |
| full_perm | output | 1 | Read/write/execute granted without walk |

## Verification
A wrong quadrant decode shows up one cycle after acceptance, as the wrong ID pair or as a missing or spurious segment fault. The bench therefore covers every quadrant in both privilege states, with nonzero register values so that a swapped source is visible. An error in the stage-flag logic is visible in the same cycle as a wrong `need_part` or `need_proc`. The hypervisor quadrant-1 case with a zero partition register is the one that separates "quadrant says partition" from "selected ID is nonzero". A corrupted handshake register appears within one stalled cycle, as outputs that change or a request that is accepted while `out_valid` waits.

// File: rtl/xctx_pkg.sv
// Shared quadrant encoding for the translation context decoder.
package xctx_pkg;
    typedef enum logic [1:0] {
        QD_USER = 2'd0,
        QD_HYP1 = 2'd1,
        QD_HYP2 = 2'd2,
        QD_KERN = 2'd3
    } quad_e;

    localparam int QBITS = 2;
endpackage

// File: rtl/xctx_quad_dec.sv
// Quadrant decoder: picks partition/process IDs from the top address bits
// and flags malformed or illegal addresses. Combinational.
// Assumes ea_hi holds the address from its MSB down to CHK_LO.
module xctx_quad_dec
    import xctx_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int CHK_LO = 52
) (
    input  logic [EA_W-1:CHK_LO] ea_hi,
    input  logic                 hv,
    input  logic                 chk_en,
    input  logic [LPID_W-1:0]    lpid_reg,
    input  logic [PID_W-1:0]     pid_reg,
    output logic                 fault,
    output logic [LPID_W-1:0]    lpid,
    output logic [PID_W-1:0]     pid
);
    localparam int CHK_HI = EA_W - QBITS - 1;

    quad_e       quad;
    logic        bad_bits;
    logic        illegal;
    logic [LPID_W-1:0] lp_sel;
    logic [PID_W-1:0]  pd_sel;

    assign quad     = quad_e'(ea_hi[EA_W-1 -: QBITS]);
    assign bad_bits = |ea_hi[CHK_HI:CHK_LO];

    // Select ID sources per quadrant and privilege state.
    always_comb begin
        illegal = 1'b0;
        lp_sel  = '0;
        pd_sel  = '0;
        if (hv) begin
            unique case (quad)
                QD_USER: begin lp_sel = '0;       pd_sel = pid_reg; end
                QD_HYP1: begin lp_sel = lpid_reg; pd_sel = pid_reg; end
                QD_HYP2: begin lp_sel = lpid_reg; pd_sel = '0;      end
                QD_KERN: begin lp_sel = '0;       pd_sel = '0;      end
            endcase
        end else begin
            unique case (quad)
                QD_USER: begin lp_sel = lpid_reg; pd_sel = pid_reg; end
                QD_HYP1,
                QD_HYP2: illegal = 1'b1;
                QD_KERN: begin lp_sel = lpid_reg; pd_sel = '0;      end
            endcase
        end
    end

    // Fault only on translated accesses; a fault clears the IDs.
    always_comb begin
        fault = chk_en && (bad_bits || illegal);
        lpid  = (fault || !chk_en) ? '0 : lp_sel;
        pid   = (fault || !chk_en) ? '0 : pd_sel;
    end
endmodule

// File: rtl/xctx_stage_sel.sv
// Stage selector and address former: decides which translation stages
// are needed and builds the outgoing address. Combinational.
// Assumes fault and lpid_sel come from the quadrant decoder for this request.
module xctx_stage_sel
    import xctx_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int RM_CLR = 4
) (
    input  logic [EA_W-1:0]   ea,
    input  logic              hv,
    input  logic              reloc,
    input  logic              fault,
    input  logic [LPID_W-1:0] lpid_sel,
    input  logic [EA_W-1:0]   rmor,
    output logic [EA_W-1:0]   addr,
    output logic              need_proc,
    output logic              need_part,
    output logic              full_perm
);
    localparam logic [EA_W-1:0] RM_MASK = {{RM_CLR{1'b0}}, {(EA_W-RM_CLR){1'b1}}};
    localparam logic [EA_W-1:0] TR_MASK = {{QBITS{1'b0}}, {(EA_W-QBITS){1'b1}}};

    logic real_hv;
    assign real_hv = hv && !reloc;

    // Choose real-mode, faulting or translated result.
    always_comb begin
        addr      = '0;
        need_proc = 1'b0;
        need_part = 1'b0;
        full_perm = 1'b0;
        if (real_hv) begin
            addr      = (ea & RM_MASK) | (ea[EA_W-1] ? '0 : rmor);
            full_perm = 1'b1;
        end else if (!fault) begin
            addr      = ea & TR_MASK;
            need_proc = reloc;
            need_part = !hv || (lpid_sel != '0);
        end
    end
endmodule

// File: rtl/xctx_out_reg.sv
// Output register with a single-entry valid/ready handshake.
// Assumes the payload is a flat vector of width W.
module xctx_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] din,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign dout      = dat_q;

    // Load on accept, drain on consume, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (in_valid && in_ready) begin
            vld_q <= 1'b1;
            dat_q <= din;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/xlate_ctx_dec.sv
// Translation context decoder top: quadrant decode, stage selection and
// a registered handshake stage. Assumes register inputs are stable for
// the cycle in which a request is accepted.
module xlate_ctx_dec
    import xctx_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int CHK_LO = 52,
    parameter int RM_CLR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [EA_W-1:0]   ea,
    input  logic              hv,
    input  logic              reloc,
    input  logic              ifetch,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [EA_W-1:0]   rmor,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              seg_fault,
    output logic              fault_ifetch,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid,
    output logic [EA_W-1:0]   raddr,
    output logic              need_proc,
    output logic              need_part,
    output logic              full_perm
);
    localparam int PW = 2 + LPID_W + PID_W + EA_W + 3;

    logic              c_fault;
    logic [LPID_W-1:0] c_lpid;
    logic [PID_W-1:0]  c_pid;
    logic [EA_W-1:0]   c_addr;
    logic              c_proc, c_part, c_perm;
    logic [PW-1:0]     c_pack, r_pack;

    xctx_quad_dec #(
        .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .CHK_LO(CHK_LO)
    ) u_quad (
        .ea_hi    (ea[EA_W-1:CHK_LO]),
        .hv       (hv),
        .chk_en   (!(hv && !reloc)),
        .lpid_reg (lpid_reg),
        .pid_reg  (pid_reg),
        .fault    (c_fault),
        .lpid     (c_lpid),
        .pid      (c_pid)
    );

    xctx_stage_sel #(
        .EA_W(EA_W), .LPID_W(LPID_W), .RM_CLR(RM_CLR)
    ) u_stage (
        .ea        (ea),
        .hv        (hv),
        .reloc     (reloc),
        .fault     (c_fault),
        .lpid_sel  (c_lpid),
        .rmor      (rmor),
        .addr      (c_addr),
        .need_proc (c_proc),
        .need_part (c_part),
        .full_perm (c_perm)
    );

    assign c_pack = {c_fault, c_fault & ifetch, c_lpid, c_pid, c_addr,
                     c_proc, c_part, c_perm};

    xctx_out_reg #(.W(PW)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .din       (c_pack),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dout      (r_pack)
    );

    assign {seg_fault, fault_ifetch, lpid, pid, raddr,
            need_proc, need_part, full_perm} = r_pack;
endmodule

// File: rtl/xctx_chk.sv
// Property checker for xlate_ctx_dec, attached by bind below.
module xctx_chk #(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int CHK_LO = 52,
    parameter int RM_CLR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [EA_W-1:0]   ea,
    input logic              hv,
    input logic              reloc,
    input logic              ifetch,
    input logic [LPID_W-1:0] lpid_reg,
    input logic [PID_W-1:0]  pid_reg,
    input logic [EA_W-1:0]   rmor,
    input logic              out_valid,
    input logic              out_ready,
    input logic              seg_fault,
    input logic              fault_ifetch,
    input logic [LPID_W-1:0] lpid,
    input logic [PID_W-1:0]  pid,
    input logic [EA_W-1:0]   raddr,
    input logic              need_proc,
    input logic              need_part,
    input logic              full_perm
);
    logic acc;
    logic guest_bad_q;
    logic hv_q0_ok;
    assign acc         = in_valid && in_ready;
    assign guest_bad_q = !hv && (ea[EA_W-1] ^ ea[EA_W-2]);
    assign hv_q0_ok    = hv && reloc && (ea[EA_W-1:EA_W-2] == 2'b00)
                         && (ea[EA_W-3:CHK_LO] == '0);

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && seg_fault |-> lpid == '0 && pid == '0 && raddr == '0
            && !need_proc && !need_part && !full_perm); // R4
    AST_IFETCH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && fault_ifetch |-> seg_fault); // R4
    AST_GUEST_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc && guest_bad_q |=> out_valid && seg_fault
            && (fault_ifetch == $past(ifetch))); // R3
    AST_HV_Q0_IDS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && hv_q0_ok |=> !seg_fault && lpid == '0
            && pid == $past(pid_reg) && need_proc && !need_part); // R2
    AST_REAL_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && hv && !reloc |=> full_perm && !seg_fault && !need_proc
            && !need_part && raddr[EA_W-1 -: RM_CLR] == '0); // R5
    AST_REAL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        acc && hv && !reloc && !ea[EA_W-1] && rmor[EA_W-RM_CLR-1:0] != '0
            |=> raddr != '0); // R5
    AST_GUEST_PART: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !hv && lpid_reg != '0 |=> seg_fault || need_part); // R6
    AST_ACCEPT_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(raddr) && $stable(lpid)
            && $stable(pid) && $stable(seg_fault) && $stable(need_part)
            && $stable(need_proc) && $stable(full_perm)); // R9
    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R9
endmodule

bind xlate_ctx_dec xctx_chk #(
    .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .CHK_LO(CHK_LO), .RM_CLR(RM_CLR)
) u_chk (.*);

// File: tb/xlate_ctx_dec_tb.sv
`timescale 1ns/1ps
module xlate_ctx_dec_tb;
    localparam logic [11:0] LPR  = 12'h5A5;
    localparam logic [19:0] PIDR = 20'h1234B;
    localparam logic [63:0] RMO  = 64'h0000_0001_0000_0000;
    localparam logic [63:0] TRM  = 64'h3FFF_FFFF_FFFF_FFFF;
    localparam int NV = 12;
    // {ea, hv, reloc, exp_fault, exp_lp_reg, exp_pid_reg, exp_proc, exp_part}
    localparam logic [70:0] VEC [NV] = '{
        {64'h0000_0000_1234_5000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {64'h4000_0000_0000_8000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {64'h8000_0000_00AB_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {64'hC000_0000_0000_0040, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {64'h0000_0000_0000_3000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {64'h4000_0000_0000_3000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {64'h8000_0000_0000_3000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {64'hC000_0000_0000_7000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {64'h0000_0000_0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {64'h0010_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {64'h2000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {64'hC000_0000_0000_0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] ea = '0;
    logic        hv = 1'b0, reloc = 1'b0, ifetch = 1'b0;
    logic [11:0] lpid_reg = LPR;
    logic [19:0] pid_reg = PIDR;
    logic [63:0] rmor = RMO;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        seg_fault, fault_ifetch, need_proc, need_part, full_perm;
    logic [11:0] lpid;
    logic [19:0] pid;
    logic [63:0] raddr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlate_ctx_dec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ea(ea), .hv(hv), .reloc(reloc), .ifetch(ifetch),
        .lpid_reg(lpid_reg), .pid_reg(pid_reg), .rmor(rmor),
        .out_valid(out_valid), .out_ready(out_ready), .seg_fault(seg_fault),
        .fault_ifetch(fault_ifetch), .lpid(lpid), .pid(pid), .raddr(raddr),
        .need_proc(need_proc), .need_part(need_part), .full_perm(full_perm)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one request on a falling edge; results are sampled one cycle later.
    task automatic send(input logic [63:0] a, input logic h, input logic r,
                        input logic f);
        @(negedge clk);
        ea = a; hv = h; reloc = r; ifetch = f;
        in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "out_valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "in_ready after reset", {63'd0, in_ready}, 64'd1);
        chk("R10", "out_valid after reset", {63'd0, out_valid}, 64'd0);

        // Table walk: R1 R2 R3 R6 R7 vectors.
        for (int i = 0; i < NV; i++) begin
            logic [63:0] va;
            logic ef, elp, epd, epr, ept;
            va = VEC[i][70:7];
            {ef, elp, epd, epr, ept} = VEC[i][4:0];
            send(va, VEC[i][6], VEC[i][5], 1'b0);
            chk("R8", $sformatf("v%0d out_valid", i), {63'd0, out_valid}, 64'd1);
            chk("R1/R3", $sformatf("v%0d seg_fault", i), {63'd0, seg_fault}, {63'd0, ef});
            chk("R2/R3", $sformatf("v%0d lpid", i), {52'd0, lpid}, elp ? {52'd0, LPR} : 64'd0);
            chk("R2/R3", $sformatf("v%0d pid", i), {44'd0, pid}, epd ? {44'd0, PIDR} : 64'd0);
            chk("R7", $sformatf("v%0d raddr", i), raddr, ef ? 64'd0 : (va & TRM));
            chk("R6", $sformatf("v%0d need_proc", i), {63'd0, need_proc}, {63'd0, epr});
            chk("R6", $sformatf("v%0d need_part", i), {63'd0, need_part}, {63'd0, ept});
            chk("R7", $sformatf("v%0d full_perm", i), {63'd0, full_perm}, 64'd0);
        end

        // R5: real mode with MSB set ignores the offset and the checked bits.
        send(64'hF030_0000_0000_1000, 1'b1, 1'b0, 1'b0);
        chk("R5", "real msb set raddr", raddr, 64'h0030_0000_0000_1000);
        chk("R5", "real msb set full_perm", {63'd0, full_perm}, 64'd1);
        chk("R5", "real no fault", {63'd0, seg_fault}, 64'd0);
        chk("R5", "real no stages", {62'd0, need_proc, need_part}, 64'd0);
        // R5: real mode with MSB clear ORs in the offset.
        send(64'h7000_0000_0000_2000, 1'b1, 1'b0, 1'b0);
        chk("R5", "real msb clear raddr", raddr, 64'h0000_0001_0000_2000);
        chk("R5", "real lpid zero", {52'd0, lpid}, 64'd0);

        // R4: fault tag follows the access type.
        send(64'h4000_0000_0000_0000, 1'b0, 1'b1, 1'b1);
        chk("R4", "ifetch fault tag", {62'd0, seg_fault, fault_ifetch}, 64'd3);
        send(64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0);
        chk("R4", "data fault tag", {62'd0, seg_fault, fault_ifetch}, 64'd2);
        send(64'h0000_0000_0000_0000, 1'b0, 1'b1, 1'b1);
        chk("R4", "no tag without fault", {63'd0, fault_ifetch}, 64'd0);

        // R6: hypervisor quadrant 1 with a zero partition register needs no partition stage.
        lpid_reg = '0;
        send(64'h4000_0000_0000_0000, 1'b1, 1'b1, 1'b0);
        chk("R6", "hv q1 lpid0 need_part", {63'd0, need_part}, 64'd0);
        chk("R6", "hv q1 lpid0 need_proc", {63'd0, need_proc}, 64'd1);
        lpid_reg = LPR;

        // R9: stall holds outputs and blocks input.
        @(negedge clk);
        ea = 64'h4000_0000_0000_5000; hv = 1'b1; reloc = 1'b1; ifetch = 1'b0;
        in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        ea = 64'hC000_0000_0000_0000; hv = 1'b0;
        chk("R9", "stalled in_ready", {63'd0, in_ready}, 64'd0);
        repeat (3) @(negedge clk);
        chk("R9", "stall out_valid", {63'd0, out_valid}, 64'd1);
        chk("R9", "stall raddr", raddr, 64'h0000_0000_0000_5000);
        chk("R9", "stall pid", {44'd0, pid}, {44'd0, PIDR});
        chk("R9", "stall lpid", {52'd0, lpid}, {52'd0, LPR});
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        chk("R8", "drained out_valid", {63'd0, out_valid}, 64'd0);
        chk("R8", "in_ready when empty", {63'd0, in_ready}, 64'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule